// File: doc/BRIEF.md
# Filtered Ping-Pong Ethernet Receive Buffer

This block is the receive half of a small memory-mapped Ethernet controller. Frame bytes arrive one per beat on a valid/ready byte stream that also carries start, end and error flags. A destination-address filter runs on every frame. It compares the first six bytes against a 48-bit station address input and also accepts any frame whose first byte has its top bit set. Bytes are packed big-endian into one of two 2 KB receive buffers as they arrive.

When a frame ends cleanly and passes the filter, the block marks the buffer it used as full. It can raise a one-cycle interrupt and, in ping-pong mode, switch to the other buffer for the next frame. A frame that targets a buffer that is still full is consumed and thrown away, and a one-cycle lost pulse reports the drop. Software reads the buffers and the control words over a simple 32-bit register bus. It hands a buffer back by clearing that buffer's full flag. No length is reported, so software scans the buffer contents to find where the frame ends.

Back-pressure rules: `rx_ready` is low only during reset and the first cycle after it. After that it stays high, and the stream is never stalled. A beat transfers on any cycle where `rx_valid` and `rx_ready` are both high. Frames that cannot be stored are dropped rather than held back.

Top module: `eth_rx_pingpong`

## Requirements
- R1: A frame passes the filter when bit 7 (mask 0x80) of its first byte is set, or when it has at least six bytes and bytes 0..5 equal `station_addr[47:40]`, `[39:32]`, ... `[7:0]` in that order.
- R2: A frame that fails the filter leaves the full flag, the active buffer and `irq` unchanged. Its bytes may still have been written into the target buffer.
- R3: If the target buffer's full flag is set when the first byte arrives, the whole frame is dropped: no byte is written, nothing else changes, and `lost_pulse` is high for the one cycle after the first beat.
- R4: An accepted frame sets the full flag S (bit 0) of its buffer's control word (byte address 0x17FC for buffer 0, 0x1FFC for buffer 1), starting the cycle after its last beat.
- R5: `irq` is high for exactly the cycle after the last beat of an accepted frame, and only when that buffer's interrupt-enable bit I (bit 3) and the global enable bit 31 of the word at 0x07F8 are both set.
- R6: While `pingpong_en` is high, the next frame goes to the active buffer, and the active buffer flips after each accepted frame. While it is low, frames always go to buffer 0 and the active buffer does not change. After reset the active buffer is buffer 0.
- R7: Byte n of a frame is stored in word n/4 of its buffer, in bits 31-8*(n%4) down to 24-8*(n%4). Buffer 0 data starts at byte address 0x1000 and buffer 1 data at 0x1800.
- R8: Bytes at frame positions 2044 and later are discarded, so the control word in the last slot of each buffer is never overwritten.
- R9: A bus write to a control word loads I from bit 3. S is cleared when bit 0 is written as 0 and is left unchanged when bit 0 is written as 1. A write to 0x07F8 loads the global enable from bit 31.
- R10: A frame with `rx_err` high on any of its beats is rejected in the same way as in R2.
- R11: `bus_rdata` shows the word addressed by `bus_re` in the following cycle. Unmapped addresses read 0. Bus writes to the buffer data area have no effect.
- R12: After reset, both control words and the global enable read 0, `irq` and `lost_pulse` are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address; bits 47:40 are compared with the first frame byte |
| pingpong_en | input | 1 | Alternate buffers between accepted frames |
| rx_valid | input | 1 | Byte stream valid |
| rx_ready | output | 1 | Byte stream ready (high after reset) |
| rx_first | input | 1 | Beat carries the first byte of a frame |
| rx_last | input | 1 | Beat carries the last byte of a frame |
| rx_err | input | 1 | Beat is errored; the frame is rejected |
| rx_data | input | 8 | Frame byte |
| bus_addr | input | 13 | Register bus byte address (word aligned) |
| bus_we | input | 1 | Register bus write strobe |
| bus_re | input | 1 | Register bus read strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| irq | output | 1 | One-cycle receive interrupt |
| lost_pulse | output | 1 | One-cycle pulse when a frame is dropped because its buffer is full |

## Verification
If the active-buffer state is wrong, the next accepted frame lands in the wrong buffer. This shows in the other control word's S bit and in the data words, which can be read one cycle after the frame's last beat. A full flag that is stuck or set when it should not be shows as a `lost_pulse` one cycle after the first byte of the next frame. A filter that holds a wrong match state either raises `irq` or fails to raise it in the cycle after the last beat. A byte index that is off by one shows up at once when the packed data words are read back.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam int CTRL_S_BIT = 0;
  localparam int CTRL_I_BIT = 3;
  localparam int GIE_BIT    = 31;

  typedef enum logic [1:0] {
    RSEL_ZERO,
    RSEL_REG,
    RSEL_MEM
  } rsel_e;

  function automatic logic [31:0] ctrl_word(input logic s, input logic i);
    logic [31:0] w;
    w = '0;
    w[CTRL_S_BIT] = s;
    w[CTRL_I_BIT] = i;
    return w;
  endfunction
endpackage

// File: rtl/eth_rx_filter.sv
module eth_rx_filter #(
  parameter int MAC_BYTES = 6,
  parameter int POS_W     = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat,
  input  logic                   first,
  input  logic [POS_W-1:0]       pos,
  input  logic [7:0]             data,
  input  logic [8*MAC_BYTES-1:0] station,
  output logic                   pass
);
  logic       mc_q, mt_q;
  logic       mc_now, mt_now;
  logic [7:0] want;

  always_comb begin
    want = '0;
    for (int k = 0; k < MAC_BYTES; k++) begin
      if (pos == POS_W'(k)) want = station[8*(MAC_BYTES-1-k) +: 8];
    end
  end

  assign mc_now = first ? data[7] : mc_q;
  assign mt_now = (first ? 1'b1 : mt_q) &
                  ((pos >= POS_W'(MAC_BYTES)) | (data == want));
  assign pass   = mc_now | (mt_now & (pos >= POS_W'(MAC_BYTES - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_q <= 1'b0;
      mt_q <= 1'b0;
    end else if (beat) begin
      mc_q <= mc_now;
      mt_q <= mt_now;
    end
  end
endmodule

// File: rtl/eth_rx_track.sv
module eth_rx_track #(
  parameter int BUF_WORDS = 512,
  parameter int POS_W     = 12,
  parameter int WORD_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic              last,
  input  logic              err,
  input  logic              pp_en,
  input  logic              active_buf,
  input  logic [1:0]        stat_s,
  output logic              act_beat,
  output logic [POS_W-1:0]  pos,
  output logic              tgt,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [1:0]        wr_lane,
  output logic              frame_end,
  output logic              frame_clean,
  output logic              lost
);
  localparam int DATA_BYTES = 4 * BUF_WORDS - 4;

  logic             in_frame_q, drop_q, tgt_q, err_q;
  logic [POS_W-1:0] idx_q;
  logic             full, err_acc;

  assign act_beat    = beat & (first | in_frame_q);
  assign pos         = first ? '0 : idx_q;
  assign tgt         = first ? (pp_en & active_buf) : tgt_q;
  assign full        = first ? stat_s[pp_en & active_buf] : drop_q;
  assign err_acc     = (first ? 1'b0 : err_q) | err;
  assign wr_en       = act_beat & ~full & (pos < POS_W'(DATA_BYTES));
  assign wr_word     = pos[WORD_W+1:2];
  assign wr_lane     = pos[1:0];
  assign frame_end   = act_beat & last;
  assign frame_clean = ~full & ~err_acc;
  assign lost        = beat & first & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      tgt_q      <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
    end else if (act_beat) begin
      in_frame_q <= ~last;
      drop_q     <= full;
      tgt_q      <= tgt;
      err_q      <= err_acc;
      idx_q      <= (pos < POS_W'(DATA_BYTES)) ? pos + 1'b1 : pos;
    end
  end
endmodule

// File: rtl/eth_rx_status.sv
module eth_rx_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        tgt,
  input  logic        pp_en,
  input  logic        lost_in,
  input  logic        we_gie,
  input  logic [1:0]  we_ctrl,
  input  logic [31:0] wdata,
  output logic        gie,
  output logic [1:0]  stat_s,
  output logic [1:0]  stat_i,
  output logic        active_buf,
  output logic        irq,
  output logic        lost_pulse
);
  import eth_rx_pkg::*;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stat_s[b] <= 1'b0;
          stat_i[b] <= 1'b0;
        end else begin
          if (accept && tgt == b[0])
            stat_s[b] <= 1'b1;
          else if (we_ctrl[b])
            stat_s[b] <= stat_s[b] & wdata[CTRL_S_BIT];
          if (we_ctrl[b])
            stat_i[b] <= wdata[CTRL_I_BIT];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie        <= 1'b0;
      active_buf <= 1'b0;
      irq        <= 1'b0;
      lost_pulse <= 1'b0;
    end else begin
      if (we_gie) gie <= wdata[GIE_BIT];
      if (accept && pp_en) active_buf <= ~active_buf;
      irq        <= accept & stat_i[tgt] & gie;
      lost_pulse <= lost_in;
    end
  end
endmodule

// File: rtl/eth_rx_store.sv
module eth_rx_store #(
  parameter int BUF_WORDS = 512,
  parameter int WORD_W    = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [1:0]        wr_lane,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              rd_buf,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data
);
  logic [31:0] mem [2*BUF_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[{wr_buf, wr_word}][8*(3 - int'(wr_lane)) +: 8] <= wr_data;
    if (rd_en)
      rd_data <= mem[{rd_buf, rd_word}];
  end
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong #(
  parameter int BUF_WORDS = 512,
  parameter int MAC_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [8*MAC_BYTES-1:0]       station_addr,
  input  logic                         pingpong_en,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic                         rx_first,
  input  logic                         rx_last,
  input  logic                         rx_err,
  input  logic [7:0]                   rx_data,
  input  logic [$clog2(BUF_WORDS)+3:0] bus_addr,
  input  logic                         bus_we,
  input  logic                         bus_re,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         irq,
  output logic                         lost_pulse
);
  import eth_rx_pkg::*;

  localparam int WORD_W   = $clog2(BUF_WORDS);
  localparam int AW       = WORD_W + 4;
  localparam int POS_W    = WORD_W + 3;
  localparam int GIE_ADDR = 4 * BUF_WORDS - 8;

  logic              ready_q;
  logic              beat, act_beat, tgt, wr_en, frame_end, frame_clean, lost, pass, accept;
  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] wr_word;
  logic [1:0]        wr_lane, stat_s, stat_i, we_ctrl;
  logic              gie_en, active_buf;
  logic              in_rx, sel_buf, is_ctrl, we_gie, mem_rd_en;
  logic [WORD_W-1:0] sel_word;
  rsel_e             rsel_q;
  logic [31:0]       reg_q, mem_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign rx_ready = ready_q;
  assign beat     = rx_valid & ready_q;
  assign accept   = frame_end & frame_clean & pass;

  eth_rx_track #(.BUF_WORDS(BUF_WORDS), .POS_W(POS_W), .WORD_W(WORD_W)) u_track (
    .clk, .rst_n, .beat, .first(rx_first), .last(rx_last), .err(rx_err),
    .pp_en(pingpong_en), .active_buf, .stat_s, .act_beat, .pos, .tgt,
    .wr_en, .wr_word, .wr_lane, .frame_end, .frame_clean, .lost
  );

  eth_rx_filter #(.MAC_BYTES(MAC_BYTES), .POS_W(POS_W)) u_filter (
    .clk, .rst_n, .beat(act_beat), .first(rx_first), .pos, .data(rx_data),
    .station(station_addr), .pass
  );

  // Bus address decode
  assign in_rx    = bus_addr[AW-1];
  assign sel_buf  = bus_addr[AW-2];
  assign sel_word = bus_addr[AW-3:2];
  assign is_ctrl  = in_rx & (sel_word == '1);
  assign we_gie   = bus_we & (bus_addr == AW'(GIE_ADDR));
  assign we_ctrl  = {bus_we & is_ctrl & sel_buf, bus_we & is_ctrl & ~sel_buf};
  assign mem_rd_en = bus_re & in_rx & ~is_ctrl;

  eth_rx_status u_status (
    .clk, .rst_n, .accept, .tgt, .pp_en(pingpong_en), .lost_in(lost),
    .we_gie, .we_ctrl, .wdata(bus_wdata), .gie(gie_en), .stat_s, .stat_i,
    .active_buf, .irq, .lost_pulse
  );

  eth_rx_store #(.BUF_WORDS(BUF_WORDS), .WORD_W(WORD_W)) u_store (
    .clk, .wr_en, .wr_buf(tgt), .wr_word, .wr_lane, .wr_data(rx_data),
    .rd_en(mem_rd_en), .rd_buf(sel_buf), .rd_word(sel_word), .rd_data(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel_q <= RSEL_ZERO;
      reg_q  <= '0;
    end else if (bus_re) begin
      if (mem_rd_en) begin
        rsel_q <= RSEL_MEM;
      end else if (is_ctrl) begin
        rsel_q <= RSEL_REG;
        reg_q  <= ctrl_word(stat_s[sel_buf], stat_i[sel_buf]);
      end else if (bus_addr == AW'(GIE_ADDR)) begin
        rsel_q <= RSEL_REG;
        reg_q  <= {gie_en, 31'b0};
      end else begin
        rsel_q <= RSEL_ZERO;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_MEM: bus_rdata = mem_rd;
      RSEL_REG: bus_rdata = reg_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eth_rx_pingpong_chk.sv
module eth_rx_pingpong_chk #(
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_first,
  input logic              rx_last,
  input logic              pingpong_en,
  input logic              irq,
  input logic              lost_pulse,
  input logic              gie_en,
  input logic              active_buf,
  input logic [1:0]        stat_s,
  input logic              wr_en,
  input logic              wr_buf,
  input logic [WORD_W-1:0] wr_word
);
  // R5: interrupt only right after a final beat
  p_irq_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid && rx_last));
  // R5: interrupt requires the global enable
  p_irq_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_en));
  // R3: drop report follows a first beat
  p_lost_on_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> $past(rx_valid && rx_first));
  // R3: never write into a full buffer
  p_no_write_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !stat_s[wr_buf]);
  // R4: full flag rises only at frame end
  p_s_rise_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_s[0]) || $rose(stat_s[1])) |-> $past(rx_valid && rx_last));
  // R8: control slot never written
  p_ctrl_slot_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_word != '1));
  // R6: buffer 0 stays active without ping-pong
  p_single_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pingpong_en && !active_buf) |=> !active_buf);
endmodule

bind eth_rx_pingpong eth_rx_pingpong_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(beat), .rx_first(rx_first),
  .rx_last(rx_last), .pingpong_en(pingpong_en), .irq(irq),
  .lost_pulse(lost_pulse), .gie_en(gie_en), .active_buf(active_buf),
  .stat_s(stat_s), .wr_en(wr_en), .wr_buf(tgt), .wr_word(wr_word)
);

// File: tb/eth_rx_pingpong_bench.sv
`timescale 1ns/1ps
module eth_rx_pingpong_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] station_addr = 48'h021A2B3C4D5E;
  logic        pingpong_en = 1'b1;
  logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic [12:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, lost_pulse;

  eth_rx_pingpong u_eth_rx_pingpong (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int expq[$];
  logic [7:0]  fbuf [0:2199];
  logic [31:0] mm [0:1023];
  logic        s_m [0:1];
  logic        i_m [0:1];
  logic        gie_m = 1'b0, act_m = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_exp(input int b);
    return {28'b0, i_m[b], 2'b0, s_m[b]};
  endfunction

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 13'h17FC || a == 13'h1FFC) begin
      int b = (a == 13'h1FFC) ? 1 : 0;
      i_m[b] = d[3];
      s_m[b] = s_m[b] & d[0];
    end else if (a == 13'h07F8) begin
      gie_m = d[31];
    end
  endtask

  task automatic bus_read_chk(input logic [12:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    chk(bus_rdata, exp, tag);
  endtask

  // Driver: computes expectations from the requirements and pushes events
  task automatic send_frame(input int n, input bit err);
    int  tgt = pingpong_en ? int'(act_m) : 0;
    bit  full = s_m[tgt];
    bit  mc = fbuf[0][7];
    bit  mt = (n >= 6);
    bit  ok;
    for (int k = 0; k < 6 && k < n; k++)
      if (fbuf[k] != station_addr[8*(5-k) +: 8]) mt = 1'b0;
    ok = !full && !err && (mc || mt);
    if (full) expq.push_back(2);
    if (ok && i_m[tgt] && gie_m) expq.push_back(1);
    if (!full)
      for (int k = 0; k < n && k < 2044; k++)
        mm[tgt*512 + k/4][8*(3 - k%4) +: 8] = fbuf[k];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_first = (k == 0); rx_last = (k == n-1);
      rx_err = err && (k == n-1); rx_data = fbuf[k];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    if (ok) begin
      s_m[tgt] = 1'b1;
      if (pingpong_en) act_m = ~act_m;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic build_uni(input int n, input logic [7:0] b0);
    for (int k = 0; k < n; k++) fbuf[k] = (k < 6) ? station_addr[8*(5-k) +: 8] : 8'(8'h10 + k);
    fbuf[0] = b0;
  endtask

  // Monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        total++;
        if (expq.size() == 0 || expq[0] != 1) begin
          bad++; $display("FAIL R5 unexpected irq actual=1 expected=0");
        end else void'(expq.pop_front());
      end
      if (lost_pulse) begin
        total++;
        if (expq.size() == 0 || expq[0] != 2) begin
          bad++; $display("FAIL R3 unexpected lost_pulse actual=1 expected=0");
        end else void'(expq.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    s_m[0] = 0; s_m[1] = 0; i_m[0] = 0; i_m[1] = 0;
    for (int k = 0; k < 1024; k++) mm[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk({31'b0, rx_ready}, 32'd1, "R12 rx_ready");
    chk({30'b0, irq, lost_pulse}, 32'd0, "R12 irq/lost");
    bus_read_chk(13'h17FC, 32'h0, "R12 ctrl0");
    bus_read_chk(13'h1FFC, 32'h0, "R12 ctrl1");
    bus_read_chk(13'h07F8, 32'h0, "R12 gie");
    // R9 enables
    bus_write(13'h07F8, 32'h8000_0000);
    bus_write(13'h17FC, 32'h8);
    bus_write(13'h1FFC, 32'h8);
    bus_read_chk(13'h07F8, 32'h8000_0000, "R9 gie write");
    bus_read_chk(13'h17FC, ctrl_exp(0), "R9 ctrl0 I");
    // R1 unicast match into buffer 0, R4, R5, R7
    build_uni(10, 8'h02);
    send_frame(10, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R4 ctrl0 S");
    bus_read_chk(13'h1000, mm[0], "R7 buf0 word0");
    bus_read_chk(13'h1004, mm[1], "R7 buf0 word1");
    bus_read_chk(13'h1008, mm[2], "R7 buf0 word2");
    // R1 multicast, R6 alternate to buffer 1
    build_uni(7, 8'h81);
    send_frame(7, 0);
    bus_read_chk(13'h1FFC, ctrl_exp(1), "R6 ctrl1 S");
    bus_read_chk(13'h1800, mm[512], "R7 buf1 word0");
    // R3 both full: dropped
    build_uni(8, 8'h02);
    send_frame(8, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R3 ctrl0 unchanged");
    bus_read_chk(13'h1000, mm[0], "R3 buf0 not written");
    // R9 release and write-one-no-set
    bus_write(13'h17FC, 32'h8);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R9 S cleared");
    bus_write(13'h17FC, 32'h9);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R9 S not set by write");
    // R2 mismatch: bytes written, no status
    build_uni(8, 8'h03);
    send_frame(8, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R2 ctrl0 after mismatch");
    bus_read_chk(13'h1000, mm[0], "R2 bytes stored");
    // R10 errored matching frame
    build_uni(9, 8'h02);
    send_frame(9, 1);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R10 ctrl0 after error");
    // R1 short unicast frame with matching prefix
    build_uni(3, 8'h02);
    send_frame(3, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R1 short frame rejected");
    // R5 gie off: accepted, no irq
    bus_write(13'h07F8, 32'h0);
    build_uni(8, 8'h02);
    send_frame(8, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R5 S set without irq");
    // R6 ping-pong off: buffer 0 only
    bus_write(13'h07F8, 32'h8000_0000);
    bus_write(13'h17FC, 32'h8);
    bus_write(13'h1FFC, 32'h8);
    pingpong_en = 1'b0;
    build_uni(6, 8'h02);
    send_frame(6, 0);
    bus_read_chk(13'h17FC, ctrl_exp(0), "R6 ctrl0 used");
    bus_read_chk(13'h1FFC, ctrl_exp(1), "R6 ctrl1 untouched");
    send_frame(6, 0);
    bus_read_chk(13'h1FFC, ctrl_exp(1), "R6 no switch when full");
    // R8 long frame into buffer 1
    pingpong_en = 1'b1;
    for (int k = 0; k < 2100; k++) fbuf[k] = 8'(k + 8'h80);
    send_frame(2100, 0);
    bus_read_chk(13'h1FF8, mm[1022], "R8 last data word");
    bus_read_chk(13'h1FFC, ctrl_exp(1), "R8 ctrl1 intact");
    bus_read_chk(13'h1C00, mm[768], "R7 buf1 mid word");
    // R11 unmapped read and data area write ignored
    bus_read_chk(13'h0004, 32'h0, "R11 unmapped");
    bus_write(13'h1000, 32'hDEAD_BEEF);
    bus_read_chk(13'h1000, mm[0], "R11 data write ignored");
    repeat (4) @(negedge clk);
    chk(32'(expq.size()), 32'd0, "R5 pending events");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule